// File: doc/BRIEF.md
# Strobed Four-Beat Burst Address Sequencer

This block sits in front of a synchronous memory array and turns a starting word address into the run of internal addresses used by a four-beat burst. A burst opens when either of two start strobes is sampled high on a rising clock edge. The processor strobe only counts while the first chip enable is low (active). The controller strobe counts regardless of that enable. On that edge the external address is captured, and the three chip enables are sampled to decide whether the block is selected.

After a selected start, each cycle with the advance input high steps the two low address bits to the next beat. The upper bits do not change. The beat order is set by a mode input: linear order counts up modulo four from the starting low bits, and interleaved order XORs the starting low bits with the beat index. If advance is low and no strobe is seen, the current address is held. A controller strobe in the middle of a burst restarts the burst at a new address. All outputs are registered and settle one clock after the edge that caused them.

Top module: `burst_addr_seq`

## Requirements
- R1: While the synchronous active-high reset `rst` is high, the next edge gives `acc_addr` = 0, `burst_on` = 0 and `sel_q` = 0.
- R2: With `cpu_stb`=1 and `ce_a_n`=0 on an edge, the block captures `addr_in` on that edge.
- R3: A start is selected when `ce_a_n`=0, `ce_b`=1 and `ce_c_n`=0 on the start edge. After a selected start, `acc_addr` equals `addr_in`, `burst_on`=1 and `sel_q`=1.
- R4: With `cpu_stb`=1, `ce_a_n`=1 and `ctl_stb`=0, the edge has no effect: `acc_addr`, `burst_on` and `sel_q` keep their values.
- R5: `ctl_stb`=1 starts the block on an edge whatever the level of `ce_a_n`. If the enables do not all sit at their active levels, the start is deselected: `sel_q`=0 and `burst_on`=0, while `acc_addr` still captures `addr_in`.
- R6: With `wrap_sel`=0 (linear), beat k (k = 0..3) has `acc_addr[1:0]` = (s + k) mod 4, where s is the starting low pair.
- R7: With `wrap_sel`=1 (interleaved), beat k has `acc_addr[1:0]` = s XOR k.
- R8: While `burst_on`=1 and no strobe is active, `adv`=1 moves to the next beat on that edge and `adv`=0 holds `acc_addr`.
- R9: An advance from beat 3 clears `burst_on` and holds `acc_addr`. While `burst_on`=0, `adv` has no effect on the outputs.
- R10: `acc_addr[AW-1:2]` is constant from a start until the next start.
- R11: `ctl_stb` during a burst reloads `acc_addr` from `addr_in` and restarts the burst at beat 0.
- R12: If both strobes are high on the same edge, exactly one start from `addr_in` takes place. With `ce_a_n`=1 that start comes from the controller strobe and is deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_in | input | AW | External word address |
| cpu_stb | input | 1 | Processor start strobe, active high, masked by ce_a_n |
| ctl_stb | input | 1 | Controller start strobe, active high |
| adv | input | 1 | Advance to next beat, active high |
| ce_a_n | input | 1 | First chip enable, active low |
| ce_b | input | 1 | Second chip enable, active high |
| ce_c_n | input | 1 | Third chip enable, active low |
| wrap_sel | input | 1 | Beat order: 1 interleaved, 0 linear |
| acc_addr | output | AW | Current internal access address |
| burst_on | output | 1 | Burst in progress |
| sel_q | output | 1 | Selection state latched at the last start |

## Verification
A wrong beat counter or wrong start value appears on `acc_addr[1:0]` one clock after the advance edge that caused it. A dropped, missed or spurious start changes either the captured upper bits or `sel_q` on the edge that follows. The sweep covers every starting low pair in both orders with each strobe, plus all eight chip-enable combinations. Every output is compared on every cycle, so any divergence is reported within one cycle of the edge that caused it.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int BEATS = 4;
  localparam int BW    = 2;

  typedef logic [BW-1:0] beat_t;

  function automatic beat_t order_low(input beat_t start, input beat_t idx, input logic ilv);
    beat_t r;
    if (ilv) r = start ^ idx;
    else     r = start + idx;
    return r;
  endfunction
endpackage

// File: rtl/strobe_gate.sv
module strobe_gate (
  input  logic cpu_stb,
  input  logic ctl_stb,
  input  logic ce_a_n,
  input  logic ce_b,
  input  logic ce_c_n,
  output logic load,
  output logic load_sel,
  output logic from_cpu
);
  logic cpu_ok;
  logic enables_ok;

  always_comb begin
    cpu_ok     = cpu_stb & ~ce_a_n;
    enables_ok = ~ce_a_n & ce_b & ~ce_c_n;
    // processor path wins when unmasked; both paths capture the same address
    from_cpu   = cpu_ok;
    load       = cpu_ok | ctl_stb;
    load_sel   = load & enables_ok;
  end
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
  import burst_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  load,
  input  logic  load_sel,
  input  logic  adv,
  output beat_t beat,
  output logic  step,
  output logic  burst_on,
  output logic  sel_q
);
  localparam beat_t LAST = beat_t'(BEATS - 1);

  logic advance;

  always_comb begin
    advance = ~load & burst_on & adv;
    step    = advance & (beat != LAST);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      beat     <= '0;
      burst_on <= 1'b0;
      sel_q    <= 1'b0;
    end else if (load) begin
      beat     <= '0;
      burst_on <= load_sel;
      sel_q    <= load_sel;
    end else if (advance) begin
      if (beat == LAST) burst_on <= 1'b0;
      else              beat     <= beat + 1'b1;
    end
  end

  AST_BEAT_RESTART: assert property (@(posedge clk) disable iff (rst)
    load |=> (beat == '0)) else $error("beat not restarted"); // R11

  AST_END_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (!load && burst_on && adv && beat == LAST) |=> !burst_on) else $error("burst did not end"); // R9
endmodule

// File: rtl/addr_track.sv
module addr_track
  import burst_pkg::*;
#(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          step,
  input  logic          wrap_sel,
  input  beat_t         beat,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] acc_addr
);
  localparam int HW = AW - BW;

  beat_t start_q;
  beat_t low_nx;

  always_comb low_nx = order_low(start_q, beat + 1'b1, wrap_sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_addr <= '0;
      start_q  <= '0;
    end else if (load) begin
      acc_addr <= addr_in;
      start_q  <= addr_in[BW-1:0];
    end else if (step) begin
      acc_addr[BW-1:0] <= low_nx;
    end
  end

  AST_HI_STABLE: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(acc_addr[AW-1:BW])) else $error("upper bits moved"); // R10

  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!load && !step) |=> $stable(acc_addr)) else $error("address moved without step"); // R8
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_pkg::*;
#(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr_in,
  input  logic          cpu_stb,
  input  logic          ctl_stb,
  input  logic          adv,
  input  logic          ce_a_n,
  input  logic          ce_b,
  input  logic          ce_c_n,
  input  logic          wrap_sel,
  output logic [AW-1:0] acc_addr,
  output logic          burst_on,
  output logic          sel_q
);
  logic  load;
  logic  load_sel;
  logic  from_cpu;
  logic  step;
  beat_t beat;

  strobe_gate u_gate (
    .cpu_stb (cpu_stb),
    .ctl_stb (ctl_stb),
    .ce_a_n  (ce_a_n),
    .ce_b    (ce_b),
    .ce_c_n  (ce_c_n),
    .load    (load),
    .load_sel(load_sel),
    .from_cpu(from_cpu)
  );

  burst_beat_ctr u_ctr (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .load_sel(load_sel),
    .adv     (adv),
    .beat    (beat),
    .step    (step),
    .burst_on(burst_on),
    .sel_q   (sel_q)
  );

  addr_track #(.AW(AW)) u_addr (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .step    (step),
    .wrap_sel(wrap_sel),
    .beat    (beat),
    .addr_in (addr_in),
    .acc_addr(acc_addr)
  );

  AST_ON_NEEDS_SEL: assert property (@(posedge clk) disable iff (rst)
    burst_on |-> sel_q) else $error("burst without select"); // R3

  AST_CPU_START: assert property (@(posedge clk) disable iff (rst)
    from_cpu |=> (acc_addr == $past(addr_in))) else $error("processor start missed"); // R2

  AST_MASKED_CPU: assert property (@(posedge clk) disable iff (rst)
    (cpu_stb && ce_a_n && !ctl_stb && !burst_on) |=> ($stable(acc_addr) && $stable(sel_q))) else $error("masked strobe acted"); // R4

  AST_CTL_START: assert property (@(posedge clk) disable iff (rst)
    ctl_stb |=> (acc_addr == $past(addr_in))) else $error("controller start missed"); // R5
endmodule

// File: tb/burst_addr_seq_test.sv
module burst_addr_seq_test;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr_in = '0;
  logic          cpu_stb = 1'b0, ctl_stb = 1'b0, adv = 1'b0;
  logic          ce_a_n = 1'b0, ce_b = 1'b1, ce_c_n = 1'b0, wrap_sel = 1'b0;
  logic [AW-1:0] acc_addr;
  logic          burst_on, sel_q;

  int total = 0;
  int bad = 0;

  logic [AW-1:0] e_addr = '0;
  logic [1:0]    e_start = '0, e_beat = '0;
  logic          e_on = 1'b0, e_sel = 1'b0;

  always #2 clk = ~clk;

  burst_addr_seq #(.AW(AW)) uut (
    .clk(clk), .rst(rst), .addr_in(addr_in), .cpu_stb(cpu_stb), .ctl_stb(ctl_stb),
    .adv(adv), .ce_a_n(ce_a_n), .ce_b(ce_b), .ce_c_n(ce_c_n), .wrap_sel(wrap_sel),
    .acc_addr(acc_addr), .burst_on(burst_on), .sel_q(sel_q)
  );

  task automatic check(input string req);
    total++;
    if (acc_addr !== e_addr || burst_on !== e_on || sel_q !== e_sel) begin
      bad++;
      $display("FAIL %s: addr=%h on=%b sel=%b expected addr=%h on=%b sel=%b",
               req, acc_addr, burst_on, sel_q, e_addr, e_on, e_sel);
    end
  endtask

  // one clock: drive now (just after a falling edge), predict, check at next falling edge
  task automatic cyc(input logic c, input logic t, input logic a, input logic [AW-1:0] ad,
                     input logic ea, input logic eb, input logic ec, input string req);
    logic go;
    cpu_stb = c; ctl_stb = t; adv = a; addr_in = ad;
    ce_a_n = ea; ce_b = eb; ce_c_n = ec;
    go = (c & ~ea) | t;
    if (go) begin
      e_addr = ad; e_start = ad[1:0]; e_beat = 2'd0;
      e_sel = ~ea & eb & ~ec; e_on = e_sel;
    end else if (e_on && a) begin
      if (e_beat == 2'd3) e_on = 1'b0;
      else begin
        e_beat = e_beat + 2'd1;
        e_addr[1:0] = wrap_sel ? (e_start ^ e_beat) : (e_start + e_beat);
      end
    end
    @(posedge clk);
    @(negedge clk);
    check(req);
  endtask

  initial begin
    #(4 * 100000);
    bad++;
    $display("FAIL watchdog: run did not finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset");
    rst = 1'b0;

    // R6 / R7 / R2 / R3 / R8 / R9 / R10: every start pair, both orders, both strobes
    for (int m = 0; m < 2; m++) begin
      wrap_sel = m[0];
      for (int s = 0; s < 4; s++) begin
        for (int k = 0; k < 2; k++) begin
          logic [AW-1:0] a0;
          a0 = AW'((s * 37 + m * 91 + k * 13) & 8'hFC) | AW'(s);
          cyc(k == 0, k == 1, 1'b0, a0, 1'b0, 1'b1, 1'b0, k == 0 ? "R2 R3 cpu start" : "R3 R5 ctl start");
          cyc(1'b0, 1'b0, 1'b0, ~a0, 1'b0, 1'b1, 1'b0, "R8 hold");
          for (int b = 1; b < 4; b++) begin
            cyc(1'b0, 1'b0, 1'b1, ~a0, 1'b0, 1'b1, 1'b0, m ? "R7 R10 interleaved beat" : "R6 R10 linear beat");
            cyc(1'b0, 1'b0, 1'b0, a0 ^ 8'h5A, 1'b0, 1'b1, 1'b0, "R8 hold mid burst");
          end
          cyc(1'b0, 1'b0, 1'b1, ~a0, 1'b0, 1'b1, 1'b0, "R9 end after beat 3");
          cyc(1'b0, 1'b0, 1'b1, ~a0, 1'b0, 1'b1, 1'b0, "R9 adv ignored when idle");
        end
      end
    end

    // R4: masked processor strobe, during idle and mid burst
    wrap_sel = 1'b0;
    cyc(1'b0, 1'b1, 1'b0, 8'h41, 1'b0, 1'b1, 1'b0, "R3 start");
    cyc(1'b1, 1'b0, 1'b0, 8'hC3, 1'b1, 1'b1, 1'b0, "R4 masked cpu mid burst");
    cyc(1'b0, 1'b0, 1'b1, 8'hC3, 1'b0, 1'b1, 1'b0, "R8 step after masked");
    // R11: controller reload mid burst
    cyc(1'b0, 1'b1, 1'b1, 8'h96, 1'b1, 1'b1, 1'b0, "R11 R5 ctl reload deselected");
    cyc(1'b0, 1'b1, 1'b0, 8'h9E, 1'b0, 1'b1, 1'b0, "R11 ctl reload");
    cyc(1'b0, 1'b0, 1'b1, 8'h00, 1'b0, 1'b1, 1'b0, "R11 step after reload");
    cyc(1'b0, 1'b1, 1'b1, 8'h27, 1'b0, 1'b1, 1'b0, "R11 reload beats adv");
    cyc(1'b0, 1'b0, 1'b1, 8'h00, 1'b0, 1'b1, 1'b0, "R11 first step from new start");

    // R5 / R4 / R12: every chip-enable combination with each strobe pattern
    for (int e = 0; e < 8; e++) begin
      for (int p = 1; p < 4; p++) begin
        logic [AW-1:0] ad;
        ad = AW'(e * 29 + p * 71);
        cyc(1'b0, 1'b1, 1'b0, 8'h10, 1'b0, 1'b1, 1'b0, "R3 prime");
        cyc(p[0], p[1], 1'b0, ad, e[0], e[1], e[2],
            p == 1 ? "R4 R5 cpu enable combo" : (p == 2 ? "R5 ctl enable combo" : "R12 both strobes"));
        cyc(1'b0, 1'b0, 1'b1, ~ad, 1'b0, 1'b1, 1'b0, "R9 R8 after combo");
      end
    end

    // R1: reset mid burst
    cyc(1'b1, 1'b0, 1'b0, 8'hEE, 1'b0, 1'b1, 1'b0, "R2 start");
    rst = 1'b1;
    e_addr = '0; e_on = 1'b0; e_sel = 1'b0; e_beat = '0; e_start = '0;
    @(posedge clk);
    @(negedge clk);
    check("R1 reset mid burst");
    rst = 1'b0;
    cyc(1'b0, 1'b0, 1'b1, 8'h33, 1'b0, 1'b1, 1'b0, "R9 adv ignored after reset");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule